// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sequences analog-to-digital conversions and comparator operations over twelve analog inputs. Software programs three byte-wide control registers through a small write/read port. Setting the start bit launches an operation. The block tells an external analog front end which input to use and when a new operation begins. It counts ticks of the conversion clock, and at the end of the timed window it captures either a result word or a single comparison bit.

Each input has a comparator-function bit. When that bit is set, the input runs a short comparator operation and the outcome goes to a per-channel bit vector. When it is clear, the input runs a full conversion and the outcome goes to that channel's result register. One-shot mode stops after one operation, clears the start bit and raises a sticky interrupt request. Repeat mode keeps converting the same input until software clears the start bit. The two sweep modes walk inputs 0 to 7 in ascending order: single sweep runs the walk once, and repeat sweep runs it without end.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all three control registers read 0, the interrupt request is 0, the sample pulse is 0, and every result register and comparison bit is 0.
- R2: Register map. Address 0 holds bits [2:0] low channel, bits [4:3] mode (00 one-shot, 01 repeat, 10 single sweep, 11 repeat sweep), bit 6 start and bit 7 plain storage; bit 5 always reads 0. Address 1 bit 3 selects 10-bit resolution and bit 2 selects the repeat sweep variant. At address 2, bit 3 = 1 selects input 8 + bits [1:0]; otherwise the channel is the low channel field. The active channel appears on afe_chan.
- R3: A start request that combines a sweep mode with an input of 8 or above is refused, and the start bit stays 0.
- R4: A conversion completes on the 59th conversion-clock tick after start at 10-bit resolution and on the 49th tick at 8-bit resolution. At 8-bit resolution the stored word keeps result bits [9:2] and has its low 2 bits at 0.
- R5: A channel whose comparator-function bit is 1 completes on the 14th tick. Its comparison bit goes to cmp_result[channel], and its result register is left unchanged.
- R6: In one-shot mode, completion stores the result in the register of the converted channel, clears the start bit and sets the interrupt request.
- R7: While an operation is active, a write to address 0 leaves bits other than the start bit unchanged.
- R8: In repeat mode, each completion overwrites the channel's result and restarts on the same channel. The start bit stays 1 and no interrupt is raised.
- R9: Writing 0 to the start bit during an operation aborts it. No result is stored and no interrupt is raised.
- R10: Single sweep converts inputs 0 to 7 in ascending order, then clears the start bit and raises the interrupt request. Repeat sweep wraps from input 7 back to input 0 and keeps the start bit set.
- R11: The interrupt request stays set until irq_ack is pulsed. If a new request and irq_ack occur in the same cycle, the request wins.
- R12: afe_sample is high for exactly one cycle at the start of each operation, including each automatic restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cmp_sel | input | 12 | Per-channel comparator-function select |
| ad_tick | input | 1 | Conversion clock enable, one cycle per tick |
| afe_chan | output | 4 | Channel driven to the analog front end |
| afe_sample | output | 1 | Start-of-operation pulse to the front end |
| afe_result | input | 10 | Conversion word from the front end |
| afe_cmp | input | 1 | Comparison bit from the front end |
| res_sel | input | 4 | Result register read index |
| res_data | output | 10 | Contents of the selected result register |
| cmp_result | output | 12 | Per-channel comparison bits |
| irq | output | 1 | Sticky interrupt request |
| irq_ack | input | 1 | Clears the interrupt request |

## Verification
The bench counts ticks up to one short of each window and confirms the operation is still running. It then gives one more tick and confirms completion, so a counter that is off by one in either direction, or that picks the wrong window length for comparator or 8-bit operation, shows up. The front-end word depends on the channel, so a design that stores a result into the wrong register, or converts the wrong input in a sweep, produces values that do not match. Further cases cover an abort in mid-window, which must leave no result and no interrupt; a reconfiguration attempt during an operation, which a design without the lock would accept; a refused start on an upper input in sweep mode; and repeat mode, which must neither raise an interrupt nor drop the start bit.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH        = 12,
  parameter int RW         = 10,
  parameter int CONV_HI    = 59,
  parameter int CONV_LO    = 49,
  parameter int CMP_TICKS  = 14,
  parameter int SWEEP_LAST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [11:0]      cmp_sel,
  input  logic             ad_tick,
  output logic [3:0]       afe_chan,
  output logic             afe_sample,
  input  logic [9:0]       afe_result,
  input  logic             afe_cmp,
  input  logic [3:0]       res_sel,
  output logic [9:0]       res_data,
  output logic [11:0]      cmp_result,
  output logic             irq,
  input  logic             irq_ack
);

  localparam int MAXT = (CONV_HI > CONV_LO) ? ((CONV_HI > CMP_TICKS) ? CONV_HI : CMP_TICKS)
                                            : ((CONV_LO > CMP_TICKS) ? CONV_LO : CMP_TICKS);
  localparam int CW  = $clog2(MAXT + 1);
  localparam int CHW = $clog2(NCH);
  localparam logic [CW-1:0] LEN_HI  = CW'(CONV_HI);
  localparam logic [CW-1:0] LEN_LO  = CW'(CONV_LO);
  localparam logic [CW-1:0] LEN_CMP = CW'(CMP_TICKS);
  localparam logic [CHW-1:0] SW_END = CHW'(SWEEP_LAST);

  localparam logic [1:0] M_ONE = 2'b00;
  localparam logic [1:0] M_REP = 2'b01;
  localparam logic [1:0] M_SWP = 2'b10;

  logic [2:0]     ch_lo;
  logic [1:0]     mode;
  logic           spare7;
  logic           busy;
  logic [7:0]     ctl1;
  logic [3:0]     ctl2;
  logic [CHW-1:0] cur;
  logic [CW-1:0]  cnt;
  logic           launch;
  logic [RW-1:0]  res_q [NCH];
  logic [NCH-1:0] cmp_q;

  function automatic logic [CHW-1:0] pick_chan(input logic [2:0] lo, input logic [3:0] ext);
    return ext[3] ? CHW'({2'b10, ext[1:0]}) : CHW'(lo);
  endfunction

  wire             w0       = reg_we && (reg_addr == 2'd0);
  wire  [CHW-1:0]  w_chan   = pick_chan(reg_wdata[2:0], ctl2);
  wire             bad_mix  = reg_wdata[4] && w_chan[CHW-1];
  wire             sw_start = w0 && !busy && reg_wdata[6] && !bad_mix;
  wire             sw_stop  = w0 && busy && !reg_wdata[6];
  wire             is_cmp   = cmp_sel[cur];
  wire  [CW-1:0]   op_len   = is_cmp ? LEN_CMP : (ctl1[3] ? LEN_HI : LEN_LO);
  wire             done     = busy && ad_tick && !sw_stop && (cnt == op_len - 1'b1);
  wire             at_end   = (cur == SW_END);
  wire             go_on    = (mode == M_REP) || (mode == 2'b11) || (mode == M_SWP && !at_end);
  wire  [CHW-1:0]  nxt      = mode[1] ? (at_end ? '0 : cur + 1'b1) : cur;

  assign afe_chan   = cur;
  assign afe_sample = launch;
  assign cmp_result = cmp_q;
  assign res_data   = (res_sel < 4'(NCH)) ? res_q[res_sel] : '0;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {spare7, busy, 1'b0, mode, ch_lo};
      2'd1:    reg_rdata = ctl1;
      2'd2:    reg_rdata = {4'b0, ctl2};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_lo  <= '0;
      mode   <= '0;
      spare7 <= 1'b0;
      busy   <= 1'b0;
      ctl1   <= '0;
      ctl2   <= '0;
      cur    <= '0;
      cnt    <= '0;
      launch <= 1'b0;
      irq    <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (w0 && !busy) begin
        ch_lo  <= reg_wdata[2:0];
        mode   <= reg_wdata[4:3];
        spare7 <= reg_wdata[7];
      end
      if (reg_we && reg_addr == 2'd1) ctl1 <= reg_wdata;
      if (reg_we && reg_addr == 2'd2) ctl2 <= reg_wdata[3:0];
      if (sw_start) begin
        busy   <= 1'b1;
        cur    <= reg_wdata[4] ? '0 : w_chan;
        cnt    <= '0;
        launch <= 1'b1;
      end else if (sw_stop) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (done) begin
        cnt <= '0;
        if (go_on) begin
          cur    <= nxt;
          launch <= 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end else if (busy && ad_tick) begin
        cnt <= cnt + 1'b1;
      end
      if (done && !go_on) irq <= 1'b1;
      else if (irq_ack)   irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
      cmp_q <= '0;
    end else if (done) begin
      if (is_cmp)       cmp_q[cur] <= afe_cmp;
      else if (ctl1[3]) res_q[cur] <= afe_result;
      else              res_q[cur] <= {afe_result[RW-1:2], 2'b00};
    end
  end

  // R6
  oneshot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == M_ONE |=> !busy && irq);

  // R8
  repeat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == M_REP |=> busy && launch && cur == $past(cur));

  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable({spare7, mode, ch_lo}));

  // R3
  upper_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(mode[1] && cur[CHW-1]));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < LEN_HI || cnt < LEN_LO || cnt < LEN_CMP);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop && !irq |=> !busy && !irq && cnt == '0);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [11:0] cmp_sel = '0;
  logic        ad_tick = 1'b0;
  logic [3:0]  afe_chan;
  logic        afe_sample;
  logic [9:0]  afe_result;
  logic        afe_cmp;
  logic [3:0]  res_sel = '0;
  logic [9:0]  res_data;
  logic [11:0] cmp_result;
  logic        irq;
  logic        irq_ack = 1'b0;

  logic [9:0]  afe_base = '0;
  logic        cmp_level = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  assign afe_result = afe_base + {6'b0, afe_chan};
  assign afe_cmp    = cmp_level;

  always #10 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_sel(cmp_sel),
    .ad_tick(ad_tick), .afe_chan(afe_chan), .afe_sample(afe_sample),
    .afe_result(afe_result), .afe_cmp(afe_cmp), .res_sel(res_sel),
    .res_data(res_data), .cmp_result(cmp_result), .irq(irq), .irq_ack(irq_ack)
  );

  // chan[15:12] cmp_fn[11] hi_res[10] base[9:0]
  localparam logic [15:0] VEC [7] = '{
    {4'd0,  1'b0, 1'b1, 10'h120},
    {4'd5,  1'b0, 1'b1, 10'h200},
    {4'd9,  1'b0, 1'b0, 10'h0F0},
    {4'd11, 1'b1, 1'b1, 10'h001},
    {4'd6,  1'b1, 1'b1, 10'h000},
    {4'd8,  1'b0, 1'b1, 10'h3F0},
    {4'd7,  1'b0, 1'b0, 10'h2AA}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic res_of(input logic [3:0] c, output logic [9:0] d);
    res_sel = c;
    #1 d = res_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ad_tick = 1'b1;
      @(negedge clk); ad_tick = 1'b0;
    end
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [9:0] dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, rv); check("R1 ctrl0", rv, 8'h00);
    rd(2'd1, rv); check("R1 ctrl1", rv, 8'h00);
    rd(2'd2, rv); check("R1 ctrl2", rv, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 sample", afe_sample, 0);
    check("R1 cmp_result", cmp_result, 0);
    res_of(4'd0, dv); check("R1 result0", dv, 0);

    // R2 bit 5 reads 0, bit 7 kept
    wr(2'd0, 8'hA0);
    rd(2'd0, rv); check("R2 bit5 zero", rv, 8'h80);
    wr(2'd0, 8'h00);

    // Vector table walk (R2 R4 R5 R6 R11 R12)
    for (int v = 0; v < 7; v++) begin
      logic [3:0] ch;
      logic cf, hr;
      logic [9:0] base, raw, expv;
      int len;
      ch = VEC[v][15:12]; cf = VEC[v][11]; hr = VEC[v][10]; base = VEC[v][9:0];
      afe_base = base; cmp_level = base[0];
      cmp_sel = cf ? (12'h001 << ch) : 12'h000;
      len = cf ? 14 : (hr ? 59 : 49);
      raw = base + {6'b0, ch};
      expv = hr ? raw : (raw & 10'h3FC);
      wr(2'd1, {4'b0, hr, 3'b0});
      if (ch >= 8) wr(2'd2, {4'b1000 | {2'b00, ch[1:0]}});
      else         wr(2'd2, 8'h00);
      wr(2'd0, {1'b0, 1'b1, 1'b0, 2'b00, ch[2:0]});
      #1;
      check("R12 sample pulse", afe_sample, 1);
      check("R2 afe_chan", afe_chan, ch);
      ticks(len - 1);
      rd(2'd0, rv); check("R4/R5 still busy", rv[6], 1);
      check("R12 single pulse", afe_sample, 0);
      ticks(1);
      rd(2'd0, rv); check("R6 start cleared", rv[6], 0);
      check("R6 irq", irq, 1);
      res_of(ch, dv);
      if (cf) begin
        check("R5 cmp bit", cmp_result[ch], base[0]);
        check("R5 result untouched", dv, 0);
      end else begin
        check("R4/R6 result", dv, expv);
      end
      repeat (3) @(negedge clk);
      check("R11 irq sticky", irq, 1);
      ack();
      check("R11 irq cleared", irq, 0);
    end
    cmp_sel = '0;
    wr(2'd2, 8'h00);

    // R7 config locked while busy
    wr(2'd1, 8'h08);
    afe_base = 10'h050;
    wr(2'd0, 8'h42);
    wr(2'd0, 8'h4D);
    rd(2'd0, rv); check("R7 locked", rv, 8'h42);
    ticks(59);
    rd(2'd0, rv); check("R7 one-shot kept", rv, 8'h02);
    res_of(4'd2, dv); check("R7 channel kept", dv, 10'h052);
    check("R7 irq", irq, 1);
    ack();

    // R9 abort
    afe_base = 10'h155;
    wr(2'd0, 8'h43);
    ticks(10);
    wr(2'd0, 8'h03);
    rd(2'd0, rv); check("R9 stopped", rv[6], 0);
    ticks(60);
    check("R9 no irq", irq, 0);
    res_of(4'd3, dv); check("R9 no result", dv, 0);

    // R8 repeat
    afe_base = 10'h100;
    wr(2'd0, 8'h4C);
    ticks(59);
    rd(2'd0, rv); check("R8 start kept", rv[6], 1);
    check("R8 no irq", irq, 0);
    check("R12 restart pulse", afe_sample, 1);
    res_of(4'd4, dv); check("R8 first result", dv, 10'h104);
    afe_base = 10'h0A0;
    ticks(59);
    res_of(4'd4, dv); check("R8 overwrite", dv, 10'h0A4);
    check("R8 same channel", afe_chan, 4);
    wr(2'd0, 8'h0C);

    // R3 upper channel with sweep refused
    wr(2'd2, 8'h09);
    wr(2'd0, 8'h50);
    rd(2'd0, rv); check("R3 refused", rv[6], 0);
    check("R3 no sample", afe_sample, 0);
    wr(2'd2, 8'h00);

    // R10 single sweep
    afe_base = 10'h010;
    wr(2'd0, 8'h50);
    ticks(7 * 59 + 58);
    rd(2'd0, rv); check("R10 sweep busy", rv[6], 1);
    check("R10 sweep at last", afe_chan, 7);
    ticks(1);
    rd(2'd0, rv); check("R10 sweep end", rv[6], 0);
    check("R10 sweep irq", irq, 1);
    for (int k = 0; k < 8; k++) begin
      res_of(4'(k), dv); check("R10 sweep result", dv, 10'h010 + 10'(k));
    end
    ack();

    // R10 repeat sweep wraps
    afe_base = 10'h020;
    wr(2'd0, 8'h58);
    ticks(9 * 59);
    rd(2'd0, rv); check("R10 rsweep busy", rv[6], 1);
    check("R10 rsweep wrapped", afe_chan, 1);
    check("R10 rsweep no irq", irq, 0);
    res_of(4'd0, dv); check("R10 rsweep ch0", dv, 10'h020);
    wr(2'd0, 8'h18);

    finish_run();
  end
endmodule